// File: doc/BRIEF.md
# Bidirectional Row-Scan Driver Core

This block is the digital heart of a row-scan driver for a display panel. A serial chain of storage stages shifts a scan token in either direction, one stage per shift-enabled rising clock edge. A parallel hold stage copies the chain while the strobe is low. A per-output resolver then turns each held bit, together with two panel-wide controls (blank and float), into one of three drive states. Several drivers can be chained through their serial end ports to cover any number of panel rows.

The two serial ends swap roles when the direction changes, so each end is split into an input, an output and an output enable. A length select lets the chain run with all of its stages or with one stage fewer. In the shorter mode, the stage at the far end for the current direction is dropped from the chain, and its output is held floating. The drive state of each output is a two-bit code. The high-voltage stages, the supplies and the input conditioning stay outside this core.

Top module: `scan_row_driver`

## Requirements
- R1: With `shift_i` high and `dir_fwd_i` high, a rising `clk_i` edge moves stage k into stage k+1 and loads stage 1 from `end_a_i`. `end_b_o` presents the last active stage.
- R2: With `shift_i` high and `dir_fwd_i` low, a rising edge moves stage k into stage k-1 and loads the top stage from `end_b_i`. `end_a_o` presents the last active stage, so reversing the direction brings a token back out of end A.
- R3: With `len_full_i` high the chain has N_STAGES (65) stages, and a bit presented at the input end appears at the output end after 65 shifts. With it low the chain is one stage shorter and the bit appears after 64 shifts. Two cascaded cores therefore delay a bit by 130 or 128 shifts.
- R4: With `shift_i` low, the chain contents and the serial outputs do not change.
- R5: `end_b_oe_o` is high exactly when `dir_fwd_i` is high, and `end_a_oe_o` is high exactly when it is low.
- R6: On each rising edge while `strobe_i` is low, the hold stage copies the whole chain. While `strobe_i` is high it keeps its contents whatever the chain does.
- R7: Output k occupies `drv_state_o[2k+1:2k]` (k from 0), coded 2'b00 floating, 2'b01 driven low, 2'b10 driven high.
- R8: With `blank_i` low and `float_n_i` low, every output reads 2'b00 whatever the held data.
- R9: With `blank_i` high, the held data has no effect: `float_n_i` low gives 2'b01 on every output, and `float_n_i` high gives 2'b10 on every output.
- R10: With `blank_i` low and `float_n_i` high, each output is the inverse of its held bit: a held 1 gives 2'b01 and a held 0 gives 2'b10.
- R11: In the short mode, the dropped output reads 2'b00 whatever the controls are. That is the last output in forward direction and the first output in reverse direction.
- R12: A low `rst_ni` clears every chain stage and every held bit at once. Release takes effect after two rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift and capture clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_i | input | 1 | Shift enable for this edge |
| dir_fwd_i | input | 1 | 1: data moves stage 1 toward the top stage; 0: the opposite way |
| len_full_i | input | 1 | 1: full chain length; 0: one stage fewer |
| strobe_i | input | 1 | 0: hold stage copies the chain; 1: hold |
| blank_i | input | 1 | Panel-wide blank control |
| float_n_i | input | 1 | Panel-wide float control, low floats when not blanked |
| end_a_i | input | 1 | Serial input at end A (forward direction) |
| end_a_o | output | 1 | Serial output at end A (reverse direction) |
| end_a_oe_o | output | 1 | Output enable for end A |
| end_b_i | input | 1 | Serial input at end B (reverse direction) |
| end_b_o | output | 1 | Serial output at end B (forward direction) |
| end_b_oe_o | output | 1 | Output enable for end B |
| drv_state_o | output | 2*N_STAGES | Two-bit drive state for each output |

## Verification
The bench builds two cores with the default of 65 stages and connects them through their serial ends. At this size the full 130- and 128-shift delays across the pair can be observed, in both directions. Filling the whole chain with one value reaches every entry of the control table on all 65 outputs at once. Because of the default length, both dropped end outputs (the first and the 65th) are exercised.

// File: rtl/scan_drv_pkg.sv
package scan_drv_pkg;

  typedef enum logic [1:0] {
    DRV_Z  = 2'b00,
    DRV_LO = 2'b01,
    DRV_HI = 2'b10
  } drv_state_e;

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/scan_shift_chain.sv
module scan_shift_chain #(
  parameter int unsigned N_STAGES = 65
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_en_i,
  input  logic                fwd_i,
  input  logic                len_full_i,
  input  logic                a_in_i,
  input  logic                b_in_i,
  output logic [N_STAGES-1:0] stage_q_o,
  output logic                a_out_o,
  output logic                b_out_o
);

  localparam int unsigned TOP   = N_STAGES - 1;
  localparam int unsigned SHORT = N_STAGES - 2;

  logic [N_STAGES-1:0] stage_q;
  logic [N_STAGES-1:0] stage_d;
  logic [N_STAGES-1:0] up_src;
  logic [N_STAGES-1:0] down_src;

  // forward: each stage takes its lower neighbour; reverse: its upper one
  assign up_src   = {stage_q[TOP-1:0], a_in_i};
  assign down_src = {b_in_i, stage_q[TOP:1]};

  always_comb begin
    stage_d = stage_q;
    if (shift_en_i) begin
      stage_d = fwd_i ? up_src : down_src;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  // short mode drops the far stage for the active direction
  assign b_out_o   = len_full_i ? stage_q[TOP] : stage_q[SHORT];
  assign a_out_o   = len_full_i ? stage_q[0]   : stage_q[1];
  assign stage_q_o = stage_q;

endmodule

// File: rtl/scan_hold_bank.sv
module scan_hold_bank #(
  parameter int unsigned N_STAGES = 65
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic [N_STAGES-1:0] data_i,
  output logic [N_STAGES-1:0] hold_q_o
);

  logic [N_STAGES-1:0] hold_q;
  logic [N_STAGES-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!strobe_i) begin
      hold_d = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign hold_q_o = hold_q;

endmodule

// File: rtl/scan_out_resolve.sv
module scan_out_resolve
  import scan_drv_pkg::*;
#(
  parameter int unsigned N_STAGES = 65
) (
  input  logic [N_STAGES-1:0]   hold_i,
  input  logic                  blank_i,
  input  logic                  float_n_i,
  input  logic                  len_full_i,
  input  logic                  fwd_i,
  output logic [2*N_STAGES-1:0] state_o
);

  localparam int unsigned TOP = N_STAGES - 1;

  logic drop_first;
  logic drop_last;

  assign drop_first = !len_full_i && !fwd_i;
  assign drop_last  = !len_full_i && fwd_i;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_out
    logic       dropped;
    drv_state_e st;

    if (k == 0) begin : g_first
      assign dropped = drop_first;
    end else if (k == TOP) begin : g_last
      assign dropped = drop_last;
    end else begin : g_mid
      assign dropped = 1'b0;
    end

    always_comb begin
      unique case ({blank_i, float_n_i})
        2'b00:   st = DRV_Z;
        2'b01:   st = hold_i[k] ? DRV_LO : DRV_HI;
        2'b10:   st = DRV_LO;
        default: st = DRV_HI;
      endcase
      if (dropped) begin
        st = DRV_Z;
      end
    end

    assign state_o[2*k +: 2] = st;
  end

endmodule

// File: rtl/scan_row_driver.sv
module scan_row_driver #(
  parameter int unsigned N_STAGES = 65
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_i,
  input  logic                  dir_fwd_i,
  input  logic                  len_full_i,
  input  logic                  strobe_i,
  input  logic                  blank_i,
  input  logic                  float_n_i,
  input  logic                  end_a_i,
  output logic                  end_a_o,
  output logic                  end_a_oe_o,
  input  logic                  end_b_i,
  output logic                  end_b_o,
  output logic                  end_b_oe_o,
  output logic [2*N_STAGES-1:0] drv_state_o
);

  logic                rst_sync_n;
  logic [N_STAGES-1:0] chain_q;
  logic [N_STAGES-1:0] hold_q;

  scan_rst_sync i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  scan_shift_chain #(.N_STAGES(N_STAGES)) i_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .shift_en_i (shift_i),
    .fwd_i      (dir_fwd_i),
    .len_full_i (len_full_i),
    .a_in_i     (end_a_i),
    .b_in_i     (end_b_i),
    .stage_q_o  (chain_q),
    .a_out_o    (end_a_o),
    .b_out_o    (end_b_o)
  );

  scan_hold_bank #(.N_STAGES(N_STAGES)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .strobe_i (strobe_i),
    .data_i   (chain_q),
    .hold_q_o (hold_q)
  );

  scan_out_resolve #(.N_STAGES(N_STAGES)) i_resolve (
    .hold_i     (hold_q),
    .blank_i    (blank_i),
    .float_n_i  (float_n_i),
    .len_full_i (len_full_i),
    .fwd_i      (dir_fwd_i),
    .state_o    (drv_state_o)
  );

  assign end_b_oe_o = dir_fwd_i;
  assign end_a_oe_o = !dir_fwd_i;

endmodule

// File: rtl/scan_row_driver_chk.sv
module scan_row_driver_chk #(
  parameter int unsigned N_STAGES = 65
) (
  input logic                  clk_i,
  input logic                  rst_n,
  input logic                  shift_i,
  input logic                  dir_fwd_i,
  input logic                  len_full_i,
  input logic                  strobe_i,
  input logic                  blank_i,
  input logic                  float_n_i,
  input logic                  end_a_i,
  input logic                  end_b_i,
  input logic                  end_a_oe_o,
  input logic                  end_b_oe_o,
  input logic [N_STAGES-1:0]   chain_q,
  input logic [N_STAGES-1:0]   hold_q,
  input logic [2*N_STAGES-1:0] drv_state_o
);

  localparam int unsigned TOP = N_STAGES - 1;

  logic [N_STAGES-1:0] is_hi;
  logic [N_STAGES-1:0] is_lo;
  logic [N_STAGES-1:0] is_z;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_dec
    assign is_hi[k] = (drv_state_o[2*k +: 2] == 2'b10);
    assign is_lo[k] = (drv_state_o[2*k +: 2] == 2'b01);
    assign is_z[k]  = (drv_state_o[2*k +: 2] == 2'b00);
  end

  assert_fwd_load_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (shift_i && dir_fwd_i) |=> (chain_q[0] == $past(end_a_i)));

  assert_rev_load_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (shift_i && !dir_fwd_i) |=> (chain_q[TOP] == $past(end_b_i)));

  assert_chain_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !shift_i |=> $stable(chain_q));

  assert_one_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones({end_a_oe_o, end_b_oe_o}) == 1);

  assert_hold_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    strobe_i |=> $stable(hold_q));

  assert_hold_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !strobe_i |=> (hold_q == $past(chain_q)));

  assert_all_float_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!blank_i && !float_n_i) |-> (is_z == {N_STAGES{1'b1}}));

  assert_blank_nohi_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (blank_i && !float_n_i) |-> (is_hi == '0));

  assert_blank_nolo_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (blank_i && float_n_i) |-> (is_lo == '0));

  assert_drop_last_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!len_full_i && dir_fwd_i) |-> is_z[TOP]);

  assert_drop_first_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!len_full_i && !dir_fwd_i) |-> is_z[0]);

endmodule

bind scan_row_driver scan_row_driver_chk #(.N_STAGES(N_STAGES)) i_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .shift_i     (shift_i),
  .dir_fwd_i   (dir_fwd_i),
  .len_full_i  (len_full_i),
  .strobe_i    (strobe_i),
  .blank_i     (blank_i),
  .float_n_i   (float_n_i),
  .end_a_i     (end_a_i),
  .end_b_i     (end_b_i),
  .end_a_oe_o  (end_a_oe_o),
  .end_b_oe_o  (end_b_oe_o),
  .chain_q     (chain_q),
  .hold_q      (hold_q),
  .drv_state_o (drv_state_o)
);

// File: tb/test_scan_row_driver.sv
module test_scan_row_driver;

  localparam int N = 65;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst_n, shift, fwd, len_full, strobe, blank, float_n, din;
  logic a_o0, a_oe0, b_o0, b_oe0, a_o1, a_oe1, b_o1, b_oe1;
  logic [W-1:0] st0, st1;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  scan_row_driver #(.N_STAGES(N)) i_scan_row_driver (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift), .dir_fwd_i(fwd),
    .len_full_i(len_full), .strobe_i(strobe), .blank_i(blank),
    .float_n_i(float_n), .end_a_i(din), .end_a_o(a_o0), .end_a_oe_o(a_oe0),
    .end_b_i(a_o1), .end_b_o(b_o0), .end_b_oe_o(b_oe0), .drv_state_o(st0)
  );

  scan_row_driver #(.N_STAGES(N)) i_scan_row_driver_b (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift), .dir_fwd_i(fwd),
    .len_full_i(len_full), .strobe_i(strobe), .blank_i(blank),
    .float_n_i(float_n), .end_a_i(b_o0), .end_a_o(a_o1), .end_a_oe_o(a_oe1),
    .end_b_i(din), .end_b_o(b_o1), .end_b_oe_o(b_oe1), .drv_state_o(st1)
  );

  // {blank, float_n, data, expected state}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00_0_00, 5'b00_1_00, 5'b01_0_10, 5'b01_1_01,
    5'b10_0_01, 5'b10_1_01, 5'b11_0_10, 5'b11_1_10
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift_once(input logic b);
    @(negedge clk);
    shift = 1'b1;
    din   = b;
    @(negedge clk);
    shift = 1'b0;
    din   = 1'b0;
  endtask

  task automatic fill(input logic b);
    for (int i = 0; i < N; i++) shift_once(b);
  endtask

  task automatic strobe_pulse();
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    strobe = 1'b1;
  endtask

  function automatic logic [W-1:0] rep(input logic [1:0] s);
    return {N{s}};
  endfunction

  task automatic pulse_run(input logic full, input logic dir, input string tag);
    int total;
    do_reset();
    len_full = full;
    fwd      = dir;
    total    = full ? 2 * N : 2 * (N - 1);
    shift_once(1'b1);
    for (int i = 1; i < total - 1; i++) shift_once(1'b0);
    check({tag, " before"}, W'(dir ? b_o1 : a_o0), W'(0));
    shift_once(1'b0);
    check({tag, " at"}, W'(dir ? b_o1 : a_o0), W'(1));
    shift_once(1'b0);
    check({tag, " after"}, W'(dir ? b_o1 : a_o0), W'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    shift = 0; fwd = 1; len_full = 1; strobe = 1;
    blank = 0; float_n = 1; din = 0; rst_n = 1;
    do_reset();

    // R12: reset state, held zeros read as driven high
    #1;
    check("R12 reset outputs", st0, rep(2'b10));
    check("R12 reset serial", W'(b_o0), W'(0));

    // R5: enables follow direction
    check("R5 fwd oe", W'({a_oe0, b_oe0}), W'(2'b01));
    fwd = 0; #1;
    check("R5 rev oe", W'({a_oe0, b_oe0}), W'(2'b10));
    fwd = 1;

    // R7 R8 R9 R10: control table over every output
    for (int v = 0; v < 8; v++) begin
      do_reset();
      len_full = 1; fwd = 1; blank = 0; float_n = 1;
      fill(VEC[v][2]);
      strobe_pulse();
      @(negedge clk);
      blank   = VEC[v][4];
      float_n = VEC[v][3];
      #1;
      check($sformatf("R7 R8 R9 R10 table row %0d", v), st0, rep(VEC[v][1:0]));
    end

    // R6: hold stage keeps ones while chain is refilled with zeros
    do_reset();
    blank = 0; float_n = 1; len_full = 1; fwd = 1;
    fill(1'b1);
    strobe_pulse();
    #1;
    check("R6 loaded", st0, rep(2'b01));
    fill(1'b0);
    #1;
    check("R6 held", st0, rep(2'b01));
    strobe_pulse();
    #1;
    check("R6 reload", st0, rep(2'b10));

    // R12: asynchronous clear in mid-cycle
    fill(1'b1);
    strobe_pulse();
    @(negedge clk);
    #5 rst_n = 1'b0;
    #1;
    check("R12 async clear", st0, rep(2'b10));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4: chain holds without shift enable
    do_reset();
    shift_once(1'b1);
    for (int i = 0; i < N - 2; i++) shift_once(1'b0);
    check("R4 pre", W'(b_o0), W'(0));
    repeat (10) @(negedge clk);
    check("R4 idle", W'(b_o0), W'(0));
    shift_once(1'b0);
    check("R4 arrive", W'(b_o0), W'(1));
    repeat (5) @(negedge clk);
    check("R4 stay", W'(b_o0), W'(1));

    // R2: reversing brings a token back out of end A
    do_reset();
    shift_once(1'b1);
    for (int i = 0; i < 9; i++) shift_once(1'b0);
    fwd = 0;
    for (int i = 0; i < 8; i++) shift_once(1'b0);
    check("R2 turn before", W'(a_o0), W'(0));
    shift_once(1'b0);
    check("R2 turn out", W'(a_o0), W'(1));
    fwd = 1;

    // R11: dropped end output in short mode
    blank = 1; float_n = 1; len_full = 0; fwd = 1; #1;
    check("R11 fwd last", W'(st0[W-1 -: 2]), W'(2'b00));
    check("R11 fwd first", W'(st0[1:0]), W'(2'b10));
    fwd = 0; #1;
    check("R11 rev first", W'(st0[1:0]), W'(2'b00));
    check("R11 rev last", W'(st0[W-1 -: 2]), W'(2'b10));
    len_full = 1; #1;
    check("R11 full both", W'({st0[W-1 -: 2], st0[1:0]}), W'(4'b1010));
    blank = 0; float_n = 1; fwd = 1;

    // R1 R2 R3: cascade delays across two cores
    pulse_run(1'b1, 1'b1, "R1 R3 fwd 130");
    pulse_run(1'b0, 1'b1, "R1 R3 fwd 128");
    pulse_run(1'b1, 1'b0, "R2 R3 rev 130");
    pulse_run(1'b0, 1'b0, "R2 R3 rev 128");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule